// File: doc/BRIEF.md
# Lockable Translation Buffer

This block is a fully associative translation buffer that maps a virtual page number to a physical page number and a cacheable attribute. Software can load entries explicitly and pin them with a lock-load command. Hardware refills arrive on a valid-qualified input and go only into slots that are not pinned. A lookup is combinational over the registered entry array, so the result appears in the same cycle as the lookup inputs. A command or refill takes effect at the next clock edge.

Pinned entries survive a global invalidate and are never chosen for replacement. Pins are placed in slot order from a lock pointer. When a single pinned entry is invalidated, its slot stays pinned but can no longer hit. The slot stays in place until an unlock-all releases every pin. Bit 0 of a control word switches translation on. With translation off, every lookup passes the page number straight through, and the cacheable attribute is chosen by whether the access is an instruction fetch or a data access.

Top module: `lockable_tlb`

## Requirements
- R1: With translation on, a lookup whose page number equals that of a valid entry raises `lk_hit` in the same cycle and returns that entry's physical page and cacheable bit. A command or refill changes lookup results from the clock edge that samples it onward.
- R2: Translation is on exactly when `ctrl_word[0]` is 1. All other bits of `ctrl_word` have no effect.
- R3: With translation off, `lk_hit` is 1 and `lk_ppn` equals `lk_vpn`. `lk_cacheable` equals `lk_side`, where 1 means an instruction fetch (cacheable) and 0 means a data access (non-cacheable).
- R4: Lock-load (`cmd_op` = 1) writes a valid, pinned entry at the lock pointer and then advances the pointer by one. The pointer starts at slot 0 after reset.
- R5: A lock-load is rejected when its page number matches a valid resident entry, or when every slot is pinned. A rejected lock-load writes nothing and raises `lock_err` for exactly the one cycle after the edge that sampled it.
- R6: Invalidate-all (`cmd_op` = 3) clears every unpinned entry. Pinned entries stay valid and keep hitting.
- R7: Invalidate-entry (`cmd_op` = 2) clears any matching entry, pinned or not. A cleared pinned slot never hits again, yet it stays pinned and still reduces the refill capacity by one.
- R8: Unlock-all (`cmd_op` = 4) clears every pin and returns the lock pointer to slot 0. Entries that were valid stay valid, and every released slot, dead ones included, can be refilled again.
- R9: Refills are placed round-robin over the slots at or above the lock pointer, wrapping back to the lock pointer after the last slot. With k slots pinned, exactly ENTRIES−k refilled translations can be resident together.
- R10: When all slots are pinned, `full` is 1 and refills are dropped. `full` is 0 otherwise.
- R11: A refill presented in the same cycle as a command (`cmd_valid` = 1) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | CTRL_W | Control word; bit 0 enables translation |
| lk_side | input | 1 | Lookup side: 1 instruction, 0 data |
| lk_vpn | input | PN_W | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PN_W | Lookup physical page number |
| lk_cacheable | output | 1 | Lookup cacheable attribute |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command: 1 lock-load, 2 invalidate-entry, 3 invalidate-all, 4 unlock-all |
| cmd_vpn | input | PN_W | Command virtual page number |
| cmd_ppn | input | PN_W | Lock-load physical page number |
| cmd_cacheable | input | 1 | Lock-load cacheable attribute |
| refill_valid | input | 1 | Refill strobe |
| refill_vpn | input | PN_W | Refill virtual page number |
| refill_ppn | input | PN_W | Refill physical page number |
| refill_cacheable | input | 1 | Refill cacheable attribute |
| lock_err | output | 1 | Rejected lock-load, one cycle |
| full | output | 1 | Every slot is pinned |

## Verification
The assertions check the following on every cycle:
- Pass-through output matches the page number and side whenever translation is off.
- A refill write never lands on a pinned slot, and at most one slot is written per refill.
- No refill is written while a command is present or while the buffer is full.
- Invalidate-all empties every unpinned slot and leaves the pinned valid set untouched.
- The lock pointer moves back only after an unlock-all.

Some behaviour appears only across sequences, so only the bench scenarios can show it:
- the refill capacity left by pinned slots and dead slots;
- which refilled translation the round-robin evicts;
- the rejection of duplicate lock-loads;
- that released dead slots become usable again.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PN_W = 20;

    typedef logic [PN_W-1:0] pn_t;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_LOCK      = 3'd1,
        CMD_INV_ENTRY = 3'd2,
        CMD_INV_ALL   = 3'd3,
        CMD_UNLOCK    = 3'd4
    } cmd_e;

    typedef struct packed {
        logic valid;
        logic locked;
        pn_t  vpn;
        pn_t  ppn;
        logic cacheable;
    } entry_t;

    function automatic entry_t make_entry(input logic pin, input pn_t v,
                                          input pn_t p, input logic c);
        entry_t e;
        e.valid     = 1'b1;
        e.locked    = pin;
        e.vpn       = v;
        e.ppn       = p;
        e.cacheable = c;
        return e;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  entry_t [ENTRIES-1:0] ents,
    input  pn_t                  vpn,
    output logic [ENTRIES-1:0]   match
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ents[i].valid && (ents[i].vpn == vpn);
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    // lowest matching slot wins
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   lock_ptr,
    input  logic               advance,
    output logic [ENTRIES-1:0] wr_onehot
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] target;
    logic [IDX_W-1:0] base;

    assign base   = lock_ptr[IDX_W-1:0];
    assign target = (CNT_W'(rr_q) < lock_ptr) ? base : rr_q;

    always_comb begin
        wr_onehot = '0;
        if (advance) wr_onehot[target] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (target == IDX_W'(ENTRIES - 1)) ? base : target + 1'b1;
        end
    end
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int CTRL_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              lk_side,
    input  logic [PN_W-1:0]   lk_vpn,
    output logic              lk_hit,
    output logic [PN_W-1:0]   lk_ppn,
    output logic              lk_cacheable,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PN_W-1:0]   cmd_vpn,
    input  logic [PN_W-1:0]   cmd_ppn,
    input  logic              cmd_cacheable,
    input  logic              refill_valid,
    input  logic [PN_W-1:0]   refill_vpn,
    input  logic [PN_W-1:0]   refill_ppn,
    input  logic              refill_cacheable,
    output logic              lock_err,
    output logic              full
);
    entry_t [ENTRIES-1:0] ents_q;
    logic [CNT_W-1:0]     lock_ptr_q;
    logic                 lock_err_q;

    logic [ENTRIES-1:0]   lk_match, cmd_match, refill_wr;
    logic [ENTRIES-1:0]   valid_vec, locked_vec;
    logic                 lk_found;
    logic [IDX_W-1:0]     lk_idx;
    logic                 xlate_on;
    logic                 is_lock, lock_go, lock_bad, refill_go;
    cmd_e                 op;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
        assign valid_vec[i]  = ents_q[i].valid;
        assign locked_vec[i] = ents_q[i].locked;
    end

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents(ents_q), .vpn(lk_vpn), .match(lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_cmd_match (
        .ents(ents_q), .vpn(cmd_vpn), .match(cmd_match)
    );

    tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .match(lk_match), .hit(lk_found), .idx(lk_idx)
    );

    assign op        = cmd_e'(cmd_op);
    assign full      = (lock_ptr_q == CNT_W'(ENTRIES));
    assign is_lock   = cmd_valid && (op == CMD_LOCK);
    assign lock_bad  = is_lock && (full || (|cmd_match));
    assign lock_go   = is_lock && !lock_bad;
    assign refill_go = refill_valid && !cmd_valid && !full;

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .lock_ptr(lock_ptr_q),
        .advance(refill_go), .wr_onehot(refill_wr)
    );

    // lookup: combinational over registered state
    assign xlate_on = ctrl_word[0];
    always_comb begin
        if (!xlate_on) begin
            lk_hit       = 1'b1;
            lk_ppn       = lk_vpn;
            lk_cacheable = lk_side;
        end else begin
            lk_hit       = lk_found;
            lk_ppn       = lk_found ? ents_q[lk_idx].ppn : '0;
            lk_cacheable = lk_found && ents_q[lk_idx].cacheable;
        end
    end

    assign lock_err = lock_err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents_q     <= '0;
            lock_ptr_q <= '0;
            lock_err_q <= 1'b0;
        end else begin
            lock_err_q <= lock_bad;
            if (cmd_valid) begin
                unique case (op)
                    CMD_LOCK: begin
                        if (lock_go) begin
                            ents_q[lock_ptr_q[IDX_W-1:0]] <=
                                make_entry(1'b1, cmd_vpn, cmd_ppn, cmd_cacheable);
                            lock_ptr_q <= lock_ptr_q + 1'b1;
                        end
                    end
                    CMD_INV_ENTRY: begin
                        for (int i = 0; i < ENTRIES; i++)
                            if (cmd_match[i]) ents_q[i].valid <= 1'b0;
                    end
                    CMD_INV_ALL: begin
                        for (int i = 0; i < ENTRIES; i++)
                            if (!ents_q[i].locked) ents_q[i].valid <= 1'b0;
                    end
                    CMD_UNLOCK: begin
                        for (int i = 0; i < ENTRIES; i++)
                            ents_q[i].locked <= 1'b0;
                        lock_ptr_q <= '0;
                    end
                    default: ;
                endcase
            end else begin
                for (int i = 0; i < ENTRIES; i++)
                    if (refill_wr[i])
                        ents_q[i] <= make_entry(1'b0, refill_vpn, refill_ppn,
                                                refill_cacheable);
            end
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int ENTRIES = 32,
    parameter int PN_W    = 20,
    parameter int CTRL_W  = 32,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [CTRL_W-1:0]  ctrl_word,
    input logic               lk_side,
    input logic [PN_W-1:0]    lk_vpn,
    input logic               lk_hit,
    input logic [PN_W-1:0]    lk_ppn,
    input logic               lk_cacheable,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic               full,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] locked_vec,
    input logic [ENTRIES-1:0] refill_wr,
    input logic [CNT_W-1:0]   lock_ptr
);
    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[0] |-> (lk_hit && lk_ppn == lk_vpn && lk_cacheable == lk_side));

    assert_refill_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        (refill_wr & locked_vec) == '0);

    assert_refill_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(refill_wr));

    assert_refill_blocked_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> refill_wr == '0);

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        full |-> refill_wr == '0);

    assert_invall_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3) |=> (valid_vec & ~locked_vec) == '0);

    assert_invall_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd3) |=>
            (valid_vec & locked_vec) == $past(valid_vec & locked_vec));

    assert_unlock_notfull_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd4) |=> (!full && locked_vec == '0));

    assert_lockptr_back_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_ptr < $past(lock_ptr)) |-> ($past(cmd_valid) && $past(cmd_op) == 3'd4));
endmodule

bind lockable_tlb tlb_checker #(
    .ENTRIES(ENTRIES), .PN_W(tlb_pkg::PN_W), .CTRL_W(CTRL_W)
) u_chk (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .lk_side(lk_side),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_cacheable(lk_cacheable), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .full(full), .valid_vec(valid_vec), .locked_vec(locked_vec),
    .refill_wr(refill_wr), .lock_ptr(lock_ptr_q)
);

// File: tb/lockable_tlb_tb.sv
`timescale 1ns/1ps
module lockable_tlb_tb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ctrl_word;
    logic        lk_side;
    logic [19:0] lk_vpn;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        lk_cacheable;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [19:0] cmd_vpn, cmd_ppn;
    logic        cmd_cacheable;
    logic        refill_valid;
    logic [19:0] refill_vpn, refill_ppn;
    logic        refill_cacheable;
    logic        lock_err, full;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lockable_tlb #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .lk_side(lk_side),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_cacheable(lk_cacheable), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vpn(cmd_vpn), .cmd_ppn(cmd_ppn), .cmd_cacheable(cmd_cacheable),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_cacheable(refill_cacheable),
        .lock_err(lock_err), .full(full)
    );

    // op codes: 0 nop, 1 lock, 2 inv-entry, 3 inv-all, 4 unlock, 7 refill (bench only)
    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic        c;
        logic [19:0] chk;
        logic        hit;
        logic [19:0] eppn;
        logic        ec;
        logic        err;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{3'd1, 20'h00020, 20'h00BBB, 1'b0, 20'h00020, 1'b1, 20'h00BBB, 1'b0, 1'b0, 4'd4}, // R4
        '{3'd7, 20'h00010, 20'h00AAA, 1'b1, 20'h00010, 1'b1, 20'h00AAA, 1'b1, 1'b0, 4'd9}, // R9
        '{3'd1, 20'h00010, 20'h00DDD, 1'b0, 20'h00010, 1'b1, 20'h00AAA, 1'b1, 1'b1, 4'd5}, // R5
        '{3'd3, 20'h00000, 20'h00000, 1'b0, 20'h00020, 1'b1, 20'h00BBB, 1'b0, 1'b0, 4'd6}, // R6
        '{3'd0, 20'h00000, 20'h00000, 1'b0, 20'h00010, 1'b0, 20'h00000, 1'b0, 1'b0, 4'd6}, // R6
        '{3'd2, 20'h00020, 20'h00000, 1'b0, 20'h00020, 1'b0, 20'h00000, 1'b0, 1'b0, 4'd7}, // R7
        '{3'd1, 20'h00030, 20'h00CCC, 1'b1, 20'h00030, 1'b1, 20'h00CCC, 1'b1, 1'b0, 4'd4}, // R4
        '{3'd4, 20'h00000, 20'h00000, 1'b0, 20'h00030, 1'b1, 20'h00CCC, 1'b1, 1'b0, 4'd8}, // R8
        '{3'd3, 20'h00000, 20'h00000, 1'b0, 20'h00030, 1'b0, 20'h00000, 1'b0, 1'b0, 4'd8}  // R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_vpn = '0; cmd_ppn = '0;
        cmd_cacheable = 1'b0; refill_valid = 1'b0; refill_vpn = '0;
        refill_ppn = '0; refill_cacheable = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle(); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at a falling edge; effect visible from the next falling edge
    task automatic apply(input logic [2:0] op, input logic [19:0] v,
                         input logic [19:0] p, input logic c);
        @(negedge clk);
        idle();
        if (op == 3'd7) begin
            refill_valid = 1'b1; refill_vpn = v; refill_ppn = p; refill_cacheable = c;
        end else if (op != 3'd0) begin
            cmd_valid = 1'b1; cmd_op = op; cmd_vpn = v; cmd_ppn = p; cmd_cacheable = c;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic probe(input string tag, input logic [19:0] v,
                         input logic eh, input logic [19:0] ep);
        lk_vpn = v;
        #1;
        check(tag, {31'd0, lk_hit}, {31'd0, eh});
        if (eh) check(tag, {12'd0, lk_ppn}, {12'd0, ep});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; ctrl_word = 32'h1; lk_side = 1'b0; lk_vpn = '0;
        idle();
        do_reset();

        // reset state: empty, not full, no error (R1, R10, R5)
        #1;
        probe("R1 reset miss", 20'h00020, 1'b0, '0);
        check("R10 reset full", {31'd0, full}, 32'd0);
        check("R5 reset err", {31'd0, lock_err}, 32'd0);

        // table walk
        for (int r = 0; r < NROWS; r++) begin
            string tag;
            apply(ROWS[r].op, ROWS[r].vpn, ROWS[r].ppn, ROWS[r].c);
            tag = $sformatf("R%0d row%0d", ROWS[r].req, r);
            lk_vpn = ROWS[r].chk;
            #1;
            check(tag, {31'd0, lk_hit}, {31'd0, ROWS[r].hit});
            if (ROWS[r].hit) begin
                check(tag, {12'd0, lk_ppn}, {12'd0, ROWS[r].eppn});
                check(tag, {31'd0, lk_cacheable}, {31'd0, ROWS[r].ec});
            end
            check(tag, {31'd0, lock_err}, {31'd0, ROWS[r].err});
        end

        // R2 / R3: pass-through, other control bits ignored
        @(negedge clk);
        ctrl_word = 32'hFFFF_FFFE; lk_vpn = 20'h12345; lk_side = 1'b1; #1;
        check("R3 pass hit", {31'd0, lk_hit}, 32'd1);
        check("R3 pass ppn", {12'd0, lk_ppn}, 32'h12345);
        check("R3 instr cacheable", {31'd0, lk_cacheable}, 32'd1);
        lk_side = 1'b0; #1;
        check("R3 data noncacheable", {31'd0, lk_cacheable}, 32'd0);
        ctrl_word = 32'h0000_0001; #1;
        check("R2 enabled miss", {31'd0, lk_hit}, 32'd0);

        // R10 / R5: pin every slot
        do_reset();
        for (int i = 0; i < N; i++) apply(3'd1, 20'h04000 + 20'(i), 20'h0A000 + 20'(i), 1'b1);
        #1;
        check("R10 full set", {31'd0, full}, 32'd1);
        apply(3'd7, 20'h05000, 20'h05555, 1'b0);
        probe("R10 refill dropped", 20'h05000, 1'b0, '0);
        apply(3'd1, 20'h06000, 20'h06666, 1'b0);
        check("R5 lock when full err", {31'd0, lock_err}, 32'd1);
        probe("R5 lock when full nowrite", 20'h06000, 1'b0, '0);
        probe("R4 first pinned", 20'h04000, 1'b1, 20'h0A000);
        probe("R4 last pinned", 20'h0401F, 1'b1, 20'h0A01F);
        apply(3'd4, '0, '0, 1'b0); #1;
        check("R8 full cleared", {31'd0, full}, 32'd0);

        // R9: three pinned, 40 refills over 29 free slots
        do_reset();
        for (int i = 0; i < 3; i++) apply(3'd1, 20'h07000 + 20'(i), 20'h07100 + 20'(i), 1'b0);
        for (int i = 0; i < 40; i++) apply(3'd7, 20'h08000 + 20'(i), 20'h09000 + 20'(i), 1'b0);
        probe("R9 evicted oldest", 20'h0800A, 1'b0, '0);
        probe("R9 oldest kept", 20'h0800B, 1'b1, 20'h0900B);
        probe("R9 newest kept", 20'h08027, 1'b1, 20'h09027);
        probe("R9 pinned survives", 20'h07000, 1'b1, 20'h07100);
        probe("R9 pinned survives2", 20'h07002, 1'b1, 20'h07102);

        // R7 / R8: dead pinned slot keeps capacity until unlock
        do_reset();
        apply(3'd1, 20'h00500, 20'h00555, 1'b0);
        apply(3'd2, 20'h00500, '0, 1'b0);
        probe("R7 dead no hit", 20'h00500, 1'b0, '0);
        for (int i = 0; i < N; i++) apply(3'd7, 20'h01000 + 20'(i), 20'h02000 + 20'(i), 1'b0);
        probe("R7 capacity reduced", 20'h01000, 1'b0, '0);
        probe("R7 newer kept", 20'h01001, 1'b1, 20'h02001);
        apply(3'd4, '0, '0, 1'b0);
        for (int i = 0; i < N - 1; i++) apply(3'd7, 20'h03000 + 20'(i), 20'h03800 + 20'(i), 1'b0);
        probe("R8 released slot reused", 20'h0301E, 1'b1, 20'h0381E);
        probe("R8 full capacity", 20'h03000, 1'b1, 20'h03800);

        // R11: refill with a command in the same cycle is dropped
        do_reset();
        @(negedge clk);
        idle();
        cmd_valid = 1'b1; cmd_op = 3'd3;
        refill_valid = 1'b1; refill_vpn = 20'h00777; refill_ppn = 20'h00888;
        @(negedge clk);
        idle();
        probe("R11 refill dropped", 20'h00777, 1'b0, '0);
        apply(3'd7, 20'h00777, 20'h00888, 1'b1);
        probe("R1 refill visible next cycle", 20'h00777, 1'b1, 20'h00888);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule